// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip's boundary-scan logic. A tester drives it with a test clock, a mode-select line, serial data in, and an active-low asynchronous reset. The block walks the sixteen-state TAP state machine. It holds a 6-bit instruction, and it routes serial data through the data register that the instruction selects. The serial output is retimed on the falling test-clock edge, and its output enable is active only while a register is being shifted.

The instruction decoder knows six opcodes. Boundary capture/drive (EXTEST) and sample/preload both select an external boundary chain, and this block models that chain as a parameterised shift and update stage. IDCODE selects a fixed 32-bit identity word. HIGHZ forces every pad of the chip to high impedance and switches off all pull resistors. Self-test selects a 2-bit status word and issues a start strobe to an external self-test engine. BYPASS selects a one-bit register. Every other opcode is treated as a reserved factory code: it behaves like bypass and leaves every control output idle. The self-test engine, the boundary cells and the pads themselves sit outside this block.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While `trst_n` is low, the controller is held in Test-Logic-Reset, independent of `tck`. The active instruction becomes IDCODE at once, so `hiz_force`, `pull_off` and `bist_start` are 0 and `tdo_oe` is 0.
- R2: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state, and the active instruction becomes IDCODE. Undriven `tms` reads as 1.
- R3: With IDCODE (000100) active, a data scan shifts out a 32-bit word, least significant bit first. Bits 31:28 are 0000, bits 27:12 are 1011000111110111, bits 11:1 are 00000010111 and bit 0 is 1. The word is 0x0B1F702F.
- R4: Capture-IR loads 000001 into the instruction shifter, so the two low bits are 01. An IR scan shifts this value out least significant bit first.
- R5: A shifted opcode becomes the active instruction only at the falling `tck` edge in Update-IR. Until then, the previous instruction and its control outputs stay in force.
- R6: BYPASS (111111) selects a one-bit register that captures 0 and delays `tdi` by one shift.
- R7: Opcodes outside the six listed ones act as bypass, and `hiz_force`, `pull_off`, `bist_start`, `bs_cap_stb` and `bs_upd_stb` stay 0.
- R8: While HIGHZ (000101) is active, `hiz_force` and `pull_off` are both 1, and the data path is the one-bit bypass register.
- R9: With self-test (000110) active, Capture-DR loads a 2-bit status word. Bit 0 is `bist_done` (1 means finished) and bit 1 is `bist_pass` (1 means pass, meaningful only when bit 0 is 1). The word shifts out bit 0 first.
- R10: `bist_start` is a single-`tck` pulse in the first cycle after entering Run-Test/Idle while self-test is active. It is never high otherwise.
- R11: EXTEST (000000) and SAMPLE/PRELOAD (000001) select a chain of `BSR_LEN` bits. `bs_cap_stb` is high in Capture-DR, which loads `bs_cap_data`. `bs_upd_stb` is high in Update-DR, and `bs_upd_data` takes the shifted contents at that state's falling edge.
- R12: `tdo` changes only on falling `tck` edges. `tdo_oe` is 1 only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| hiz_force | output | 1 | Forces all chip pads to high impedance |
| pull_off | output | 1 | Disables all pad pull resistors |
| bist_start | output | 1 | Self-test start pulse |
| bist_done | input | 1 | Self-test finished flag |
| bist_pass | input | 1 | Self-test pass flag |
| bs_cap_stb | output | 1 | Boundary-chain capture strobe |
| bs_upd_stb | output | 1 | Boundary-chain update strobe |
| bs_cap_data | input | BSR_LEN | Parallel values loaded into the boundary chain at capture |
| bs_upd_data | output | BSR_LEN | Parallel boundary values latched at update |

## Verification
The bench builds the block with its default parameters: a 6-bit instruction register, an 8-bit boundary chain, and the default identity fields. An 8-bit chain is long enough for distinct non-symmetric patterns on capture and on update, so bit-order or off-by-one slips show up in both directions. The default identity value gives a 32-bit scan in which every field boundary can be seen. The 6-bit instruction register can reach all six listed opcodes and also a reserved code (101010).

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
package jtag_tap_pkg;

   typedef enum logic [3:0] {
      TAP_TLR     = 4'd0,
      TAP_RTI     = 4'd1,
      TAP_SEL_DR  = 4'd2,
      TAP_CAP_DR  = 4'd3,
      TAP_SH_DR   = 4'd4,
      TAP_EX1_DR  = 4'd5,
      TAP_PAU_DR  = 4'd6,
      TAP_EX2_DR  = 4'd7,
      TAP_UPD_DR  = 4'd8,
      TAP_SEL_IR  = 4'd9,
      TAP_CAP_IR  = 4'd10,
      TAP_SH_IR   = 4'd11,
      TAP_EX1_IR  = 4'd12,
      TAP_PAU_IR  = 4'd13,
      TAP_EX2_IR  = 4'd14,
      TAP_UPD_IR  = 4'd15
   } tap_state_t;

   typedef enum logic [1:0] {
      DSEL_BYP  = 2'd0,
      DSEL_ID   = 2'd1,
      DSEL_STAT = 2'd2,
      DSEL_BSR  = 2'd3
   } dr_sel_t;

   localparam int unsigned ID_W   = 32;
   localparam int unsigned STAT_W = 2;

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
   import jtag_tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state,
   output logic       rti_entry
);

   tap_state_t st_q;
   tap_state_t st_nxt;
   logic       rti_entry_q;

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         TAP_TLR:    st_nxt = tms ? TAP_TLR    : TAP_RTI;
         TAP_RTI:    st_nxt = tms ? TAP_SEL_DR : TAP_RTI;
         TAP_SEL_DR: st_nxt = tms ? TAP_SEL_IR : TAP_CAP_DR;
         TAP_CAP_DR: st_nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
         TAP_SH_DR:  st_nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
         TAP_EX1_DR: st_nxt = tms ? TAP_UPD_DR : TAP_PAU_DR;
         TAP_PAU_DR: st_nxt = tms ? TAP_EX2_DR : TAP_PAU_DR;
         TAP_EX2_DR: st_nxt = tms ? TAP_UPD_DR : TAP_SH_DR;
         TAP_UPD_DR: st_nxt = tms ? TAP_SEL_DR : TAP_RTI;
         TAP_SEL_IR: st_nxt = tms ? TAP_TLR    : TAP_CAP_IR;
         TAP_CAP_IR: st_nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
         TAP_SH_IR:  st_nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
         TAP_EX1_IR: st_nxt = tms ? TAP_UPD_IR : TAP_PAU_IR;
         TAP_PAU_IR: st_nxt = tms ? TAP_EX2_IR : TAP_PAU_IR;
         TAP_EX2_IR: st_nxt = tms ? TAP_UPD_IR : TAP_SH_IR;
         TAP_UPD_IR: st_nxt = tms ? TAP_SEL_DR : TAP_RTI;
         default:    st_nxt = TAP_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         st_q        <= TAP_TLR;
         rti_entry_q <= 1'b0;
      end else begin
         st_q        <= st_nxt;
         rti_entry_q <= (st_nxt == TAP_RTI) && (st_q != TAP_RTI);
      end
   end

   assign state     = st_q;
   assign rti_entry = rti_entry_q;

endmodule

// File: rtl/jtag_tap_ir.sv
`timescale 1ns/1ps
module jtag_tap_ir
   import jtag_tap_pkg::*;
#(
   parameter int unsigned          IR_W   = 6,
   parameter logic [IR_W-1:0]      RST_OP = 6'b000100
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  tap_state_t      state,
   output logic [IR_W-1:0] ir_cur,
   output logic            ir_lsb
);

   localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

   logic [IR_W-1:0] sh_q;
   logic [IR_W-1:0] cur_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh_q <= CAP_PAT;
      end else if (state == TAP_CAP_IR) begin
         sh_q <= CAP_PAT;
      end else if (state == TAP_SH_IR) begin
         sh_q <= {tdi, sh_q[IR_W-1:1]};
      end
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         cur_q <= RST_OP;
      end else if (state == TAP_TLR) begin
         cur_q <= RST_OP;
      end else if (state == TAP_UPD_IR) begin
         cur_q <= sh_q;
      end
   end

   assign ir_cur = cur_q;
   assign ir_lsb = sh_q[0];

endmodule

// File: rtl/jtag_tap_dr.sv
`timescale 1ns/1ps
module jtag_tap_dr
   import jtag_tap_pkg::*;
#(
   parameter int unsigned       BSR_LEN  = 8,
   parameter logic [ID_W-1:0]   ID_VALUE = 32'h0000_0001,
   localparam int unsigned      BSR_W    = (BSR_LEN > 0) ? BSR_LEN : 1
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tdi,
   input  tap_state_t       state,
   input  dr_sel_t          sel,
   input  logic             bist_done,
   input  logic             bist_pass,
   input  logic [BSR_W-1:0] bs_cap_data,
   output logic [BSR_W-1:0] bs_upd_data,
   output logic             dr_lsb
);

   logic              byp_q;
   logic [ID_W-1:0]   id_q;
   logic [STAT_W-1:0] stat_q;
   logic              bsr_lsb;

   wire cap_en = (state == TAP_CAP_DR);
   wire sh_en  = (state == TAP_SH_DR);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp_q <= 1'b0;
      end else if (sel == DSEL_BYP) begin
         if (cap_en)     byp_q <= 1'b0;
         else if (sh_en) byp_q <= tdi;
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         id_q <= '0;
      end else if (sel == DSEL_ID) begin
         if (cap_en)     id_q <= ID_VALUE;
         else if (sh_en) id_q <= {tdi, id_q[ID_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         stat_q <= '0;
      end else if (sel == DSEL_STAT) begin
         if (cap_en)     stat_q <= {bist_pass, bist_done};
         else if (sh_en) stat_q <= {tdi, stat_q[STAT_W-1:1]};
      end
   end

   generate
      if (BSR_LEN > 0) begin : g_bsr
         logic [BSR_LEN-1:0] chain_q;
         logic [BSR_LEN-1:0] hold_q;

         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n) begin
               chain_q <= '0;
            end else if (sel == DSEL_BSR) begin
               if (cap_en)     chain_q <= bs_cap_data;
               else if (sh_en) chain_q <= {tdi, chain_q[BSR_LEN-1:1]};
            end
         end

         always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n) begin
               hold_q <= '0;
            end else if ((state == TAP_UPD_DR) && (sel == DSEL_BSR)) begin
               hold_q <= chain_q;
            end
         end

         assign bsr_lsb     = chain_q[0];
         assign bs_upd_data = hold_q;
      end else begin : g_no_bsr
         assign bsr_lsb     = 1'b0;
         assign bs_upd_data = '0;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         DSEL_ID:   dr_lsb = id_q[0];
         DSEL_STAT: dr_lsb = stat_q[0];
         DSEL_BSR:  dr_lsb = bsr_lsb;
         default:   dr_lsb = byp_q;
      endcase
   end

endmodule

// File: rtl/jtag_tap_ctrl.sv
`timescale 1ns/1ps
module jtag_tap_ctrl
   import jtag_tap_pkg::*;
#(
   parameter int unsigned          IR_W        = 6,
   parameter int unsigned          BSR_LEN     = 8,
   parameter int unsigned          ID_VAR_W    = 4,
   parameter int unsigned          ID_PART_W   = 16,
   parameter int unsigned          ID_MFR_W    = 11,
   parameter logic [ID_VAR_W-1:0]  ID_VARIANT  = 4'b0000,
   parameter logic [ID_PART_W-1:0] ID_PART     = 16'b1011_0001_1111_0111,
   parameter logic [ID_MFR_W-1:0]  ID_MFR      = 11'b000_0001_0111,
   parameter logic [IR_W-1:0]      OP_EXTEST   = 6'b000000,
   parameter logic [IR_W-1:0]      OP_SAMPLE   = 6'b000001,
   parameter logic [IR_W-1:0]      OP_IDCODE   = 6'b000100,
   parameter logic [IR_W-1:0]      OP_HIGHZ    = 6'b000101,
   parameter logic [IR_W-1:0]      OP_SELFTEST = 6'b000110,
   parameter logic [IR_W-1:0]      OP_BYPASS   = {IR_W{1'b1}},
   localparam int unsigned         BSR_W       = (BSR_LEN > 0) ? BSR_LEN : 1
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   output logic             tdo_oe,
   output logic             hiz_force,
   output logic             pull_off,
   output logic             bist_start,
   input  logic             bist_done,
   input  logic             bist_pass,
   output logic             bs_cap_stb,
   output logic             bs_upd_stb,
   input  logic [BSR_W-1:0] bs_cap_data,
   output logic [BSR_W-1:0] bs_upd_data
);

   localparam logic [ID_W-1:0] ID_VALUE = {ID_VARIANT, ID_PART, ID_MFR, 1'b1};
   localparam bit              HAS_BSR  = (BSR_LEN > 0);

   generate
      if (IR_W < 3) begin : g_chk_irw
         $error("IR_W must hold the 3-bit low opcodes and the 01 capture pattern");
      end
      if (ID_VAR_W + ID_PART_W + ID_MFR_W + 1 != ID_W) begin : g_chk_id
         $error("identity fields must add up to 32 bits");
      end
      if (BSR_LEN == 1) begin : g_chk_bsr
         $error("BSR_LEN must be 0 or at least 2");
      end
   endgenerate

   tap_state_t      st;
   logic            rti_entry;
   logic [IR_W-1:0] ir_cur;
   logic            ir_lsb;
   logic            dr_lsb;
   dr_sel_t         sel;
   logic            is_hiz;
   logic            is_bist;
   logic            is_bs;
   logic            tdo_q;
   logic            oe_q;

   jtag_tap_fsm u_fsm (
      .tck       (tck),
      .trst_n    (trst_n),
      .tms       (tms),
      .state     (st),
      .rti_entry (rti_entry)
   );

   jtag_tap_ir #(
      .IR_W   (IR_W),
      .RST_OP (OP_IDCODE)
   ) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .state  (st),
      .ir_cur (ir_cur),
      .ir_lsb (ir_lsb)
   );

   always_comb begin
      sel     = DSEL_BYP;
      is_hiz  = 1'b0;
      is_bist = 1'b0;
      is_bs   = 1'b0;
      if (ir_cur == OP_IDCODE) begin
         sel = DSEL_ID;
      end else if (ir_cur == OP_SELFTEST) begin
         sel     = DSEL_STAT;
         is_bist = 1'b1;
      end else if (ir_cur == OP_HIGHZ) begin
         is_hiz = 1'b1;
      end else if ((ir_cur == OP_EXTEST) || (ir_cur == OP_SAMPLE)) begin
         if (HAS_BSR) begin
            sel   = DSEL_BSR;
            is_bs = 1'b1;
         end
      end
   end

   jtag_tap_dr #(
      .BSR_LEN  (BSR_LEN),
      .ID_VALUE (ID_VALUE)
   ) u_dr (
      .tck         (tck),
      .trst_n      (trst_n),
      .tdi         (tdi),
      .state       (st),
      .sel         (sel),
      .bist_done   (bist_done),
      .bist_pass   (bist_pass),
      .bs_cap_data (bs_cap_data),
      .bs_upd_data (bs_upd_data),
      .dr_lsb      (dr_lsb)
   );

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         tdo_q <= (st == TAP_SH_IR) ? ir_lsb : dr_lsb;
         oe_q  <= (st == TAP_SH_IR) || (st == TAP_SH_DR);
      end
   end

   assign tdo        = tdo_q;
   assign tdo_oe     = oe_q;
   assign hiz_force  = is_hiz;
   assign pull_off   = is_hiz;
   assign bist_start = rti_entry & is_bist;
   assign bs_cap_stb = is_bs & (st == TAP_CAP_DR);
   assign bs_upd_stb = is_bs & (st == TAP_UPD_DR);

endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_chk
   import jtag_tap_pkg::*;
#(
   parameter int unsigned IR_W = 6
) (
   input logic            tck,
   input logic            trst_n,
   input logic            tms,
   input tap_state_t      state,
   input logic [IR_W-1:0] ir_cur,
   input logic            tdo_oe,
   input logic            hiz_force,
   input logic            bist_start,
   input logic            bs_cap_stb,
   input logic            bs_upd_stb
);

   logic [2:0] hi_cnt;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)            hi_cnt <= 3'd0;
      else if (!tms)          hi_cnt <= 3'd0;
      else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
   end

   p_tms_reset_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (hi_cnt == 3'd5) |-> (state == TAP_TLR));

   p_oe_shift_r12: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe |-> ((state == TAP_SH_IR) || (state == TAP_SH_DR)));

   p_ir_update_r5: assert property (@(posedge tck) disable iff (!trst_n)
      !$stable(ir_cur) |-> ((state == TAP_UPD_IR) || (state == TAP_TLR)));

   p_hiz_rise_r8: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(hiz_force) |-> (state == TAP_UPD_IR));

   p_bist_pulse_r10: assert property (@(posedge tck) disable iff (!trst_n)
      bist_start |=> !bist_start);

   p_bist_idle_r10: assert property (@(posedge tck) disable iff (!trst_n)
      bist_start |-> (state == TAP_RTI));

   p_strobe_excl_r11: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({bs_cap_stb, bs_upd_stb, bist_start}));

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk #(.IR_W(IR_W)) u_chk (
   .tck        (tck),
   .trst_n     (trst_n),
   .tms        (tms),
   .state      (st),
   .ir_cur     (ir_cur),
   .tdo_oe     (tdo_oe),
   .hiz_force  (hiz_force),
   .bist_start (bist_start),
   .bs_cap_stb (bs_cap_stb),
   .bs_upd_stb (bs_upd_stb)
);

// File: tb/jtag_tap_ctrl_tb.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_tb;

   localparam int BSR_LEN = 8;
   localparam int IR_W    = 6;
   localparam logic [31:0] ID_EXP = {4'b0000, 16'b1011_0001_1111_0111, 11'b000_0001_0111, 1'b1};

   logic tck = 1'b0;
   always #4 tck = ~tck;

   // pins float high when the tester stops driving them
   logic drv_en = 1'b1;
   logic tms_r = 1'b1, tdi_r = 1'b0, trst_r = 1'b0;
   wire  tms_w  = drv_en ? tms_r  : 1'b1;
   wire  tdi_w  = drv_en ? tdi_r  : 1'b1;
   wire  trst_w = drv_en ? trst_r : 1'b1;

   logic bist_done = 1'b0, bist_pass = 1'b0;
   logic [BSR_LEN-1:0] bs_cap_data = '0;
   logic [BSR_LEN-1:0] bs_upd_data;
   logic tdo, tdo_oe, hiz_force, pull_off, bist_start, bs_cap_stb, bs_upd_stb;

   jtag_tap_ctrl #(.BSR_LEN(BSR_LEN)) u_dut (
      .tck(tck), .trst_n(trst_w), .tms(tms_w), .tdi(tdi_w),
      .tdo(tdo), .tdo_oe(tdo_oe), .hiz_force(hiz_force), .pull_off(pull_off),
      .bist_start(bist_start), .bist_done(bist_done), .bist_pass(bist_pass),
      .bs_cap_stb(bs_cap_stb), .bs_upd_stb(bs_upd_stb),
      .bs_cap_data(bs_cap_data), .bs_upd_data(bs_upd_data)
   );

   typedef struct { string req; logic [63:0] val; } item_t;
   item_t       exp_q[$];
   logic [63:0] act_q[$];
   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   // monitor: pops results and compares them with the expected items
   initial begin
      forever begin
         wait (act_q.size() != 0);
         begin
            logic [63:0] a;
            item_t e;
            a = act_q.pop_front();
            n_tests++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL unmatched result: actual %h expected none", a);
            end else begin
               e = exp_q.pop_front();
               if (a !== e.val) begin
                  n_fail++;
                  $display("FAIL %s: actual %h expected %h", e.req, a, e.val);
               end
            end
         end
      end
   end

   task automatic expect_item(input string req, input logic [63:0] v);
      exp_q.push_back('{req, v});
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      expect_item(req, exp);
      act_q.push_back(act);
   endtask

   task automatic step(input logic m, input logic d);
      tms_r = m;
      tdi_r = d;
      @(negedge tck);
      #1;
   endtask

   // from Run-Test/Idle, load an opcode; ends in Run-Test/Idle
   task automatic load_ir(input logic [IR_W-1:0] op, output logic [IR_W-1:0] cap,
                          output logic hz_mid);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < IR_W; i++) begin
         cap[i] = tdo;
         step(i == IR_W - 1, op[i]);
      end
      hz_mid = hiz_force;
      step(1, 0);
      step(0, 0);
   endtask

   // from Run-Test/Idle, scan n bits; ends in Run-Test/Idle
   task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                          output logic cap_seen, output logic upd_seen,
                          output logic oe_in, output logic oe_out);
      dout = '0;
      step(1, 0);
      step(0, 0);
      cap_seen = bs_cap_stb;
      step(0, 0);
      oe_in = tdo_oe;
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         step(i == n - 1, din[i]);
      end
      oe_out = tdo_oe;
      step(1, 0);
      upd_seen = bs_upd_stb;
      step(0, 0);
   endtask

   function automatic logic [63:0] byp_exp(input int n, input logic [63:0] din);
      logic [63:0] m;
      m = (64'd1 << n) - 64'd1;
      return (din << 1) & m;
   endfunction

   initial begin
      logic [IR_W-1:0] cap;
      logic hz_mid, cs, us, oi, oo;
      logic [63:0] d;
      @(negedge tck); #1;
      repeat (3) step(1, 0);
      // R1 reset state while trst_n is low
      check("R1 hiz_force in reset", hiz_force, 0);
      check("R1 pull_off in reset", pull_off, 0);
      check("R1 tdo_oe in reset", tdo_oe, 0);
      check("R1 bist_start in reset", bist_start, 0);
      trst_r = 1'b1;
      step(0, 0);

      // R3 identity word after reset, R12 enable window, R11 no strobe
      expect_item("R3 idcode value", {32'd0, ID_EXP});
      scan_dr(32, 64'd0, d, cs, us, oi, oo);
      act_q.push_back(d);
      check("R12 tdo_oe in Shift-DR", oi, 1);
      check("R12 tdo_oe after Shift-DR", oo, 0);
      check("R11 no capture strobe under IDCODE", cs, 0);

      // R12 tdo holds across rising edge
      step(1, 0); step(0, 0); step(0, 0);
      begin
         logic t0;
         t0 = tdo;
         tms_r = 0;
         @(posedge tck); #1;
         check("R12 tdo stable at rising edge", tdo, t0);
         @(negedge tck); #1;
         check("R12 tdo next id bit after falling edge", tdo, ID_EXP[1]);
      end
      step(1, 0); step(1, 0); step(0, 0);

      // R4/R5/R8 HIGHZ
      load_ir(6'b000101, cap, hz_mid);
      check("R4 captured IR pattern", cap, 6'b000001);
      check("R5 old instruction kept before Update-IR", hz_mid, 0);
      check("R8 hiz_force under HIGHZ", hiz_force, 1);
      check("R8 pull_off under HIGHZ", pull_off, 1);
      expect_item("R8 bypass path under HIGHZ", byp_exp(4, 64'hB));
      scan_dr(4, 64'hB, d, cs, us, oi, oo);
      act_q.push_back(d);

      // R2 release the pins: five floating-high tms cycles
      step(1, 0); step(0, 0); step(0, 0);
      drv_en = 1'b0;
      repeat (5) begin @(negedge tck); #1; end
      drv_en = 1'b1;
      check("R2 hiz_force cleared by tms reset", hiz_force, 0);
      step(0, 0);
      expect_item("R2 IDCODE after tms reset", {32'd0, ID_EXP});
      scan_dr(32, 64'd0, d, cs, us, oi, oo);
      act_q.push_back(d);

      // R6 bypass
      load_ir(6'b111111, cap, hz_mid);
      expect_item("R6 bypass delay", byp_exp(8, 64'hA5));
      scan_dr(8, 64'hA5, d, cs, us, oi, oo);
      act_q.push_back(d);

      // R7 reserved opcode
      load_ir(6'b101010, cap, hz_mid);
      check("R7 hiz_force idle", hiz_force, 0);
      check("R7 pull_off idle", pull_off, 0);
      check("R7 bist_start idle", bist_start, 0);
      expect_item("R7 reserved acts as bypass", byp_exp(8, 64'h3C));
      scan_dr(8, 64'h3C, d, cs, us, oi, oo);
      act_q.push_back(d);
      check("R7 no capture strobe", cs, 0);
      check("R7 no update strobe", us, 0);

      // R9/R10 self-test
      bist_done = 1'b0; bist_pass = 1'b1;
      load_ir(6'b000110, cap, hz_mid);
      check("R10 start pulse on entering idle", bist_start, 1);
      step(0, 0);
      check("R10 start pulse lasts one cycle", bist_start, 0);
      expect_item("R9 status running", 64'b10);
      scan_dr(2, 64'd0, d, cs, us, oi, oo);
      act_q.push_back(d);
      bist_done = 1'b1; bist_pass = 1'b1;
      expect_item("R9 status done pass", 64'b11);
      scan_dr(2, 64'd0, d, cs, us, oi, oo);
      act_q.push_back(d);
      bist_done = 1'b1; bist_pass = 1'b0;
      expect_item("R9 status done fail", 64'b01);
      scan_dr(2, 64'd0, d, cs, us, oi, oo);
      act_q.push_back(d);

      // R11 sample/preload and boundary drive
      bs_cap_data = 8'h5A;
      load_ir(6'b000001, cap, hz_mid);
      expect_item("R11 sample capture data", 64'h5A);
      scan_dr(8, 64'hC3, d, cs, us, oi, oo);
      act_q.push_back(d);
      check("R11 capture strobe", cs, 1);
      check("R11 update strobe", us, 1);
      check("R11 update data", bs_upd_data, 8'hC3);
      bs_cap_data = 8'h0F;
      load_ir(6'b000000, cap, hz_mid);
      expect_item("R11 extest capture data", 64'h0F);
      scan_dr(8, 64'h81, d, cs, us, oi, oo);
      act_q.push_back(d);
      check("R11 extest update data", bs_upd_data, 8'h81);

      // R1 asynchronous reset between edges
      load_ir(6'b000101, cap, hz_mid);
      check("R1 HIGHZ active before reset", hiz_force, 1);
      trst_r = 1'b0;
      #1;
      check("R1 asynchronous reset clears HIGHZ", hiz_force, 0);
      #1;
      trst_r = 1'b1;
      @(negedge tck); #1;

      wait (act_q.size() == 0);
      #1;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule